// File: doc/BRIEF.md
# Timer-Paced Serial DAC Waveform Streamer

The block sits on the host side of a 16-bit serial DAC link and keeps the converter supplied with samples without software help. A reload down-counter produces one sample tick every `tick_period` system clocks. On each tick that finds the serializer idle, the block builds a command word and shifts it out as two 8-bit bursts. Chip select and frame sync stay low around the pair of bursts.

Two waveform sources are selectable. The ramp source keeps a 12-bit counter that steps by 4 per tick, which gives a sawtooth of 1024 steps. The table source plays a fixed 32-sample sine period through a wrapping pointer. Both sources set the top nibble of the word to the fast-settling control code. Clearing `enable` abandons any word in flight, returns the link lines to idle and restarts both sources.

Top module: `wave_dac_streamer`

## Requirements
- R1: While reset is asserted and afterwards until a word starts, `cs_n`, `fs_n` and `sclk` are high and `din` and `overrun` are low.
- R2: With `enable` high, sample ticks occur exactly every `tick_period` clocks (a value of 0 or 1 ticks every clock), so successive falling edges of `fs_n` are `tick_period` clocks apart when no tick is dropped.
- R3: In ramp mode (`table_mode`=0) each accepted tick replaces the counter with (counter + 4) AND 0x0FFC and sends counter OR 0x4000. The first word after enable is 0x4004, 0x4FFC is followed by 0x4000, and 0x4000 is followed by 0x4004.
- R4: In table mode (`table_mode`=1) the k-th word after enable is 0x4000 OR (C(k mod 32) shifted left by 2), where C(i) = round(512 + 511*sin(2*pi*i/32)). The first word is therefore 0x4800, and the 33rd word repeats it.
- R5: In every word, `cs_n` falls at least one serial half period before `fs_n` falls, and `fs_n` rises at least one half period before `cs_n` rises. `fs_n` is never low while `cs_n` is high, and exactly 16 falling `sclk` edges occur while `fs_n` is low.
- R6: Bits leave MSB first. `din` changes only while `sclk` is high and is stable through each falling `sclk` edge, where the receiver samples it.
- R7: The 16 bits go out as two bursts of 8 clocks. Between the 8th and 9th falling edges, `sclk` idles high for one extra half period, so that interval is longer than the spacing of falling edges inside a burst.
- R8: Each `sclk` half period lasts `DIV` system clocks. The default of 4 at a 125 MHz system clock gives 15.625 MHz, below the 20 MHz limit.
- R9: A tick that arrives while a word is still being sent is dropped: `overrun` pulses high for one clock and the counter or pointer does not advance, so the next word sent is the next value in sequence.
- R10: One clock after `enable` is sampled low, `cs_n`, `fs_n` and `sclk` are high, even in the middle of a word. The next word after re-enabling is the first word of the selected mode (0x4004 or 0x4800).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the timer and serializer; low resets the sources |
| table_mode | input | 1 | 0 selects ramp, 1 selects sine table |
| tick_period | input | PERIOD_W | Sample period in system clocks |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial data, MSB first |
| fs_n | output | 1 | Active-low frame sync |
| cs_n | output | 1 | Active-low chip select |
| overrun | output | 1 | One-clock pulse for each dropped tick |

## Verification
The checker watches, on every cycle, the nesting of frame sync inside chip select, the stability of `din` while `sclk` is low, the minimum `sclk` phase length, the link going idle the clock after `enable` drops, and the rule that `overrun` only follows a cycle with a word in flight. Word values, ramp wrap-around, the table pointer wrap and its sine codes, the tick spacing, and the extra gap between the two bursts can only be shown by the bench's scenarios. The bench decodes the serial stream at the pins and compares each word with an independently computed sequence.

// File: rtl/wave_dac_streamer.sv
module wave_dac_streamer #(
  parameter int DIV      = 4,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                table_mode,
  input  logic [PERIOD_W-1:0] tick_period,
  output logic                sclk,
  output logic                din,
  output logic                fs_n,
  output logic                cs_n,
  output logic                overrun
);

  localparam int         DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [3:0] CTRL  = 4'h4;

  typedef enum logic [2:0] {S_IDLE, S_CSLEAD, S_FSLEAD, S_SHIFT, S_GAP, S_FSTRAIL} st_t;

  function automatic logic [9:0] sine_code(input logic [4:0] k);
    case (k)
      5'd0:  sine_code = 10'd512;
      5'd1:  sine_code = 10'd612;
      5'd2:  sine_code = 10'd708;
      5'd3:  sine_code = 10'd796;
      5'd4:  sine_code = 10'd873;
      5'd5:  sine_code = 10'd937;
      5'd6:  sine_code = 10'd984;
      5'd7:  sine_code = 10'd1013;
      5'd8:  sine_code = 10'd1023;
      5'd9:  sine_code = 10'd1013;
      5'd10: sine_code = 10'd984;
      5'd11: sine_code = 10'd937;
      5'd12: sine_code = 10'd873;
      5'd13: sine_code = 10'd796;
      5'd14: sine_code = 10'd708;
      5'd15: sine_code = 10'd612;
      5'd16: sine_code = 10'd512;
      5'd17: sine_code = 10'd412;
      5'd18: sine_code = 10'd316;
      5'd19: sine_code = 10'd228;
      5'd20: sine_code = 10'd151;
      5'd21: sine_code = 10'd87;
      5'd22: sine_code = 10'd40;
      5'd23: sine_code = 10'd11;
      5'd24: sine_code = 10'd1;
      5'd25: sine_code = 10'd11;
      5'd26: sine_code = 10'd40;
      5'd27: sine_code = 10'd87;
      5'd28: sine_code = 10'd151;
      5'd29: sine_code = 10'd228;
      5'd30: sine_code = 10'd316;
      default: sine_code = 10'd412;
    endcase
  endfunction

  st_t                 state;
  logic [PERIOD_W-1:0] tmr;
  logic [DIV_W-1:0]    div_cnt;
  logic [11:0]         ramp_cnt;
  logic [4:0]          ptr;
  logic [15:0]         shreg;
  logic [2:0]          bit_cnt;
  logic                half;
  logic                second;

  wire [PERIOD_W-1:0] reload    = (tick_period == '0) ? '0 : tick_period - PERIOD_W'(1);
  wire                tick      = enable && (tmr == '0);
  wire                busy      = (state != S_IDLE);
  wire                step      = (div_cnt == DIV_W'(DIV - 1));
  wire [11:0]         ramp_next = (ramp_cnt + 12'd4) & 12'hFFC;

  assign cs_n = (state == S_IDLE);
  assign fs_n = !(state == S_FSLEAD || state == S_SHIFT || state == S_GAP);
  assign sclk = !(state == S_SHIFT && half);
  assign din  = shreg[15];

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state    <= S_IDLE;
      tmr      <= rst_n ? reload : '0;
      div_cnt  <= '0;
      ramp_cnt <= '0;
      ptr      <= '0;
      shreg    <= '0;
      bit_cnt  <= '0;
      half     <= 1'b0;
      second   <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      overrun <= tick && busy;
      tmr     <= tick ? reload : tmr - PERIOD_W'(1);
      if (state == S_IDLE) begin
        div_cnt <= '0;
        if (tick) begin
          state   <= S_CSLEAD;
          bit_cnt <= '0;
          half    <= 1'b0;
          second  <= 1'b0;
          if (table_mode) begin
            shreg <= {CTRL, sine_code(ptr), 2'b00};
            ptr   <= ptr + 5'd1;
          end else begin
            shreg    <= {CTRL, ramp_next};
            ramp_cnt <= ramp_next;
          end
        end
      end else begin
        div_cnt <= step ? '0 : div_cnt + DIV_W'(1);
        if (step) begin
          case (state)
            S_CSLEAD:  state <= S_FSLEAD;
            S_FSLEAD:  state <= S_SHIFT;
            S_GAP:     state <= S_SHIFT;
            S_FSTRAIL: state <= S_IDLE;
            S_SHIFT: begin
              if (!half) begin
                half <= 1'b1;
              end else begin
                half    <= 1'b0;
                shreg   <= {shreg[14:0], 1'b0};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                  if (second) state <= S_FSTRAIL;
                  else begin
                    second <= 1'b1;
                    state  <= S_GAP;
                  end
                end
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/wave_dac_streamer_chk.sv
module wave_dac_streamer_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sclk,
  input logic din,
  input logic fs_n,
  input logic cs_n,
  input logic overrun
);

  AST_FS_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n) !fs_n |-> !cs_n); // R5

  AST_SCLK_ONLY_FRAMED: assert property (@(posedge clk) disable iff (!rst_n) !sclk |-> !fs_n); // R7

  AST_DIN_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n) (!sclk && !$past(sclk)) |-> $stable(din)); // R6

  AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> (cs_n && fs_n && sclk)); // R10

  AST_OVERRUN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> $past(!cs_n)); // R9

  generate
    if (DIV >= 2) begin : g_phase
      AST_SCLK_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n || !enable) $fell(sclk) |=> !sclk); // R8
      AST_SCLK_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n || !enable) ($rose(sclk) && !fs_n) |=> sclk); // R8
    end
  endgenerate

endmodule

bind wave_dac_streamer wave_dac_streamer_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sclk(sclk), .din(din),
  .fs_n(fs_n), .cs_n(cs_n), .overrun(overrun)
);

// File: tb/wave_dac_streamer_bench.sv
`timescale 1ns/1ps
module wave_dac_streamer_bench;

  localparam int    NCAP  = 1100;
  localparam real   TCLK  = 8.0;
  localparam int    WDOG  = 195000;

  typedef struct packed {
    logic        mode;
    logic [15:0] period;
    logic [15:0] nwords;
    logic [15:0] first;
    logic [15:0] last;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 16'd200, 16'd6,    16'h4004, 16'h4018},
    '{1'b1, 16'd160, 16'd33,   16'h4800, 16'h4800},
    '{1'b0, 16'd146, 16'd1025, 16'h4004, 16'h4004},
    '{1'b1, 16'd145, 16'd10,   16'h4800, 16'h4FD4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        tmode = 1'b0;
  logic [15:0] period = 16'd200;
  logic        sclk, din, fs_n, cs_n, overrun;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int novr = 0;

  logic [15:0] cap [NCAP];
  real         gap [NCAP];
  int          ncap = 0;
  int          nfs = 0;
  real         last_fs = 0.0;
  logic [15:0] sh = '0;
  int          nb = 0;
  real         fall_t [17];

  wave_dac_streamer u_wave_dac_streamer (
    .clk(clk), .rst_n(rst_n), .enable(en), .table_mode(tmode), .tick_period(period),
    .sclk(sclk), .din(din), .fs_n(fs_n), .cs_n(cs_n), .overrun(overrun)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int sine_ref(input int k);
    real v;
    v = 512.0 + 511.0 * $sin(2.0 * 3.14159265358979 * k / 32.0);
    return $rtoi(v + 0.5);
  endfunction

  function automatic logic [15:0] word_ref(input logic m, input int k);
    if (m) return 16'h4000 | 16'(sine_ref(k % 32) << 2);
    return 16'h4000 | 16'((4 * (k + 1)) % 4096);
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (overrun) novr++;
  end

  always @(negedge fs_n) if (en) begin
    chk(!cs_n, "R5 cs low before fs", cs_n, 0);
    if (nfs > 0 && nfs < NCAP) gap[nfs] = $realtime - last_fs;
    last_fs = $realtime;
    nfs++;
    nb = 0;
  end

  always @(negedge sclk) if (!fs_n) begin
    sh = {sh[14:0], din};
    if (nb < 17) fall_t[nb] = $realtime;
    nb++;
  end

  always @(posedge fs_n) if (en) begin
    chk(nb == 16, "R5 sixteen clocks", nb, 16);
    chk(!cs_n, "R5 fs rises before cs", cs_n, 0);
    if (nb == 16) begin
      chk(fall_t[1] - fall_t[0] >= 50.0, "R8 sclk period", $rtoi(fall_t[1] - fall_t[0]), 50);
      chk(fall_t[8] - fall_t[7] > fall_t[1] - fall_t[0], "R7 byte gap",
          $rtoi(fall_t[8] - fall_t[7]), $rtoi(fall_t[1] - fall_t[0]));
    end
    if (ncap < NCAP) cap[ncap] = sh;
    ncap++;
  end

  task automatic stop_run();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(cs_n && fs_n && sclk, "R10 idle after disable", {cs_n, fs_n, sclk}, 3'b111);
    repeat (2) @(negedge clk);
  endtask

  task automatic start_run(input logic m, input int p);
    ncap = 0;
    nfs = 0;
    novr = 0;
    @(negedge clk);
    tmode = m;
    period = 16'(p);
    en = 1'b1;
  endtask

  task automatic wait_words(input int n);
    while (ncap < n) @(negedge clk);
  endtask

  initial begin
    while (cycles < WDOG) @(negedge clk);
    chk(1'b0, "watchdog", cycles, WDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && fs_n && sclk && !din && !overrun, "R1 reset state",
        {cs_n, fs_n, sclk, din, overrun}, 5'b11100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n && fs_n && sclk && !overrun, "R1 idle after reset", {cs_n, fs_n, sclk, overrun}, 4'b1110);

    for (int v = 0; v < 4; v++) begin
      start_run(VECS[v].mode, int'(VECS[v].period));
      wait_words(int'(VECS[v].nwords));
      stop_run();
      chk(cap[0] == VECS[v].first, VECS[v].mode ? "R4 first word" : "R3 first word",
          cap[0], VECS[v].first);
      chk(cap[VECS[v].nwords - 1] == VECS[v].last, VECS[v].mode ? "R4 last word" : "R3 last word",
          cap[VECS[v].nwords - 1], VECS[v].last);
      for (int k = 0; k < int'(VECS[v].nwords); k++)
        if (cap[k] != word_ref(VECS[v].mode, k))
          chk(1'b0, VECS[v].mode ? "R4 R6 word" : "R3 R6 word", cap[k], word_ref(VECS[v].mode, k));
      checks++;
      for (int k = 1; k < int'(VECS[v].nwords); k++)
        if (gap[k] < TCLK * VECS[v].period - 0.01 || gap[k] > TCLK * VECS[v].period + 0.01)
          chk(1'b0, "R2 tick spacing", $rtoi(gap[k]), $rtoi(TCLK * VECS[v].period));
      checks++;
      chk(novr == 0, "R9 no overrun when slow", novr, 0);
    end

    start_run(1'b0, 1023);
    wait_words(1);
    chk(cap[0] == 16'h4004, "R3 ramp 4095 path", cap[0], 16'h4004);
    stop_run();

    start_run(1'b0, 1);
    wait_words(3);
    stop_run();
    chk(novr >= 3 * 140, "R9 overrun pulses", novr, 3 * 140);
    chk(cap[0] == 16'h4004 && cap[1] == 16'h4008 && cap[2] == 16'h400C,
        "R9 no skipped samples", cap[2], 16'h400C);
    chk(gap[1] >= 144.0 * TCLK - 0.01, "R2 period one back to back", $rtoi(gap[1]), 144 * 8);

    start_run(1'b0, 200);
    wait_words(2);
    while (fs_n) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(!cs_n && !fs_n, "R10 mid frame", {cs_n, fs_n}, 2'b00);
    stop_run();
    chk(ncap == 2 && cap[1] == 16'h4008, "R10 two words before abort", cap[1], 16'h4008);
    start_run(1'b0, 200);
    wait_words(1);
    stop_run();
    chk(cap[0] == 16'h4004, "R10 ramp restarts", cap[0], 16'h4004);

    start_run(1'b1, 200);
    wait_words(3);
    while (fs_n) @(negedge clk);
    repeat (30) @(negedge clk);
    stop_run();
    chk(cap[2] == word_ref(1'b1, 2), "R4 third table word", cap[2], word_ref(1'b1, 2));
    start_run(1'b1, 200);
    wait_words(1);
    stop_run();
    chk(cap[0] == 16'h4800, "R10 pointer restarts", cap[0], 16'h4800);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule